// File: doc/BRIEF.md
# Flash Read-Margin Command Unit

This unit sits inside a flash memory controller that serves a program-flash array and a data-flash array. It runs exactly one command: choosing the read margin level that the arrays' read paths use from then on. A host first writes parameter words into an indexed parameter register set. It selects a slot with the index register and writes a word into that slot. It then pulses the launch strobe while the completion flag is high. Pulsing the launch strobe is how the host clears the completion flag, and clearing that flag starts the command.

Before anything changes, the unit validates the launch. It checks the parameter index, the operating mode, the command code, the target address field and the margin code. If any check fails, the unit raises a sticky access-error flag, leaves both stored margins as they were, and restores the completion flag one cycle later. If every check passes, the unit waits a parameterised number of cycles and then writes the new level. A level aimed at program flash is written to both read paths. A level aimed at data flash is written to the data-flash path only. On that same edge the completion flag comes back.

Top module: `fmc_margin_unit`

## Requirements
- R1: After reset the completion flag is 1, the access-error flag is 0, and both margin outputs read 0 (normal level).
- R2: A launch pulse while the completion flag is 1 clears the flag at that clock edge. A launch pulse while the flag is 0 has no effect.
- R3: A valid launch aimed at program flash (address field = 3) writes the margin code to both the program-flash and data-flash margin outputs. The completion flag returns APPLY_LAT cycles after the launch edge (default 3).
- R4: A valid launch aimed at data flash (address field = 0) changes only the data-flash margin output.
- R5: A launch while the special-mode input is 0 raises the access error.
- R6: A launch with the parameter index at any value other than 1 raises the access error.
- R7: The address field is the low byte of parameter word 0. A value that is neither 3 nor 0 raises the access error.
- R8: The margin code is the whole of parameter word 1. Codes 0 (normal), 1 (user level 1) and 2 (user level 0) are accepted. Any other code raises the access error.
- R9: The command code is the top byte of parameter word 0. Any value other than 0x0E raises the access error.
- R10: On a failed launch both margins stay unchanged, and the completion flag returns one cycle after the launch edge, together with the access error.
- R11: The access-error flag stays set until the host pulses the error-clear input. When an error is raised in the same cycle as a clear, the flag ends up set.
- R12: The protection-violation output and the two margin-status outputs are always 0.
- R13: Index and parameter-word writes made while a command is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| special_mode | input | 1 | 1 when the chip is in special (test) mode |
| idx_we | input | 1 | Write strobe for the parameter index |
| idx_wdata | input | 3 | New parameter index |
| word_we | input | 1 | Write strobe for the parameter word at the current index |
| word_wdata | input | 16 | Parameter word data |
| launch_req | input | 1 | Launch strobe (clears the completion flag) |
| err_clr | input | 1 | Clear strobe for the access-error flag |
| cmd_done | output | 1 | Completion flag |
| acc_err | output | 1 | Sticky access-error flag |
| prot_viol | output | 1 | Protection-violation flag, always 0 |
| margin_stat | output | 2 | Margin status flags, always 0 |
| pf_margin | output | 2 | Margin code used by program-flash reads |
| df_margin | output | 2 | Margin code used by data-flash reads |

## Verification
The host's error-clear strobe and the raising of a new access error by a failed launch can land on the same edge. The bench provokes this by launching a command that is known to be invalid and then holding error-clear high on exactly the edge where the failure is reported. It expects the flag to read 1 afterwards. The bench also places a clear on a quiet cycle on its own and expects the flag to drop, so it can tell a "set wins" design from a "clear wins" design.

// File: rtl/fmc_pkg.sv
package fmc_pkg;
   localparam logic [7:0] CMD_SET_MARGIN = 8'h0E;
   localparam int NUM_SLOTS = 2;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_DATA = 2'd1,
      TGT_PROG = 2'd2
   } target_e;

   typedef struct packed {
      logic       err;
      target_e    tgt;
      logic [1:0] level;
   } check_t;
endpackage

// File: rtl/fmc_param_regs.sv
module fmc_param_regs #(
   parameter int IDX_W  = 3,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock,
   input  logic              idx_we,
   input  logic [IDX_W-1:0]  idx_wdata,
   input  logic              word_we,
   input  logic [WORD_W-1:0] word_wdata,
   output logic [IDX_W-1:0]  idx,
   output logic [WORD_W-1:0] word0,
   output logic [WORD_W-1:0] word1
);
   import fmc_pkg::*;

   logic [WORD_W-1:0] slot [NUM_SLOTS];

   initial begin
      assert (IDX_W >= 1) else $error("IDX_W must be at least 1");
      assert ((1 << IDX_W) >= NUM_SLOTS) else $error("IDX_W too small for the slots");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idx <= '0;
      else if (idx_we && !lock) idx <= idx_wdata;
   end

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) slot[g] <= '0;
         else if (word_we && !lock && (idx == IDX_W'(g))) slot[g] <= word_wdata;
      end
   end

   assign word0 = slot[0];
   assign word1 = slot[1];
endmodule

// File: rtl/fmc_margin_check.sv
module fmc_margin_check #(
   parameter int IDX_W   = 3,
   parameter int WORD_W  = 16,
   parameter int PF_ADDR = 3,
   parameter int DF_ADDR = 0
) (
   input  logic              special_mode,
   input  logic [IDX_W-1:0]  idx,
   input  logic [WORD_W-1:0] word0,
   input  logic [WORD_W-1:0] word1,
   output fmc_pkg::check_t   chk
);
   import fmc_pkg::*;

   localparam int AF_W = WORD_W - 8;

   logic [7:0]      cmd_code;
   logic [AF_W-1:0] addr_fld;
   logic            bad_idx, bad_mode, bad_cmd, bad_addr, bad_lvl;
   target_e         tgt;

   initial begin
      assert (WORD_W >= 16) else $error("WORD_W must be at least 16");
      assert (PF_ADDR != DF_ADDR) else $error("array addresses must differ");
   end

   assign cmd_code = word0[WORD_W-1 -: 8];
   assign addr_fld = word0[AF_W-1:0];

   always_comb begin
      if (addr_fld == AF_W'(PF_ADDR))      tgt = TGT_PROG;
      else if (addr_fld == AF_W'(DF_ADDR)) tgt = TGT_DATA;
      else                                 tgt = TGT_NONE;
   end

   assign bad_idx  = (idx != IDX_W'(1));
   assign bad_mode = !special_mode;
   assign bad_cmd  = (cmd_code != CMD_SET_MARGIN);
   assign bad_addr = (tgt == TGT_NONE);
   assign bad_lvl  = (word1 > WORD_W'(2));

   assign chk.err   = bad_idx | bad_mode | bad_cmd | bad_addr | bad_lvl;
   assign chk.tgt   = tgt;
   assign chk.level = word1[1:0];
endmodule

// File: rtl/fmc_margin_store.sv
module fmc_margin_store (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             apply,
   input  fmc_pkg::target_e tgt,
   input  logic [1:0]       level,
   output logic [1:0]       pf_margin,
   output logic [1:0]       df_margin
);
   import fmc_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pf_margin <= 2'd0;
         df_margin <= 2'd0;
      end else if (apply) begin
         if (tgt == TGT_PROG) begin
            pf_margin <= level;
            df_margin <= level;
         end else if (tgt == TGT_DATA) begin
            df_margin <= level;
         end
      end
   end
endmodule

// File: rtl/fmc_margin_unit.sv
module fmc_margin_unit #(
   parameter int IDX_W     = 3,
   parameter int WORD_W    = 16,
   parameter int PF_ADDR   = 3,
   parameter int DF_ADDR   = 0,
   parameter int APPLY_LAT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              special_mode,
   input  logic              idx_we,
   input  logic [IDX_W-1:0]  idx_wdata,
   input  logic              word_we,
   input  logic [WORD_W-1:0] word_wdata,
   input  logic              launch_req,
   input  logic              err_clr,
   output logic              cmd_done,
   output logic              acc_err,
   output logic              prot_viol,
   output logic [1:0]        margin_stat,
   output logic [1:0]        pf_margin,
   output logic [1:0]        df_margin
);
   import fmc_pkg::*;

   localparam int CNT_W = (APPLY_LAT > 1) ? $clog2(APPLY_LAT) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(APPLY_LAT - 1);

   logic [IDX_W-1:0]  idx;
   logic [WORD_W-1:0] word0, word1;
   check_t            chk;
   logic              launch, pend_err, apply, set_err;
   target_e           tgt_q;
   logic [1:0]        lvl_q;
   logic [CNT_W-1:0]  cnt;

   initial begin
      assert (APPLY_LAT >= 1) else $error("APPLY_LAT must be at least 1");
   end

   fmc_param_regs #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .lock       (!cmd_done),
      .idx_we     (idx_we),
      .idx_wdata  (idx_wdata),
      .word_we    (word_we),
      .word_wdata (word_wdata),
      .idx        (idx),
      .word0      (word0),
      .word1      (word1)
   );

   fmc_margin_check #(.IDX_W(IDX_W), .WORD_W(WORD_W),
                      .PF_ADDR(PF_ADDR), .DF_ADDR(DF_ADDR)) u_check (
      .special_mode (special_mode),
      .idx          (idx),
      .word0        (word0),
      .word1        (word1),
      .chk          (chk)
   );

   assign launch  = launch_req && cmd_done;
   assign set_err = !cmd_done && pend_err;

   generate
      if (APPLY_LAT == 1) begin : g_lat1
         assign apply = !cmd_done && !pend_err;
      end else begin : g_latn
         assign apply = !cmd_done && !pend_err && (cnt == LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_done <= 1'b1;
         pend_err <= 1'b0;
         tgt_q    <= TGT_NONE;
         lvl_q    <= 2'd0;
         cnt      <= '0;
      end else if (launch) begin
         cmd_done <= 1'b0;
         pend_err <= chk.err;
         tgt_q    <= chk.tgt;
         lvl_q    <= chk.level;
         cnt      <= '0;
      end else if (!cmd_done) begin
         if (set_err || apply) cmd_done <= 1'b1;
         else                  cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc_err <= 1'b0;
      else if (set_err) acc_err <= 1'b1;
      else if (err_clr) acc_err <= 1'b0;
   end

   fmc_margin_store u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .apply     (apply),
      .tgt       (tgt_q),
      .level     (lvl_q),
      .pf_margin (pf_margin),
      .df_margin (df_margin)
   );

   assign prot_viol   = 1'b0;
   assign margin_stat = 2'b00;
endmodule

// File: rtl/fmc_margin_unit_chk.sv
module fmc_margin_unit_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       launch_req,
   input logic       err_clr,
   input logic       cmd_done,
   input logic       acc_err,
   input logic [1:0] pf_margin,
   input logic [1:0] df_margin
);
   assert_done_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_done) |-> $past(launch_req));

   assert_pf_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pf_margin) |-> (df_margin == pf_margin) && $rose(cmd_done));

   assert_df_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(df_margin) |-> $rose(cmd_done));

   assert_level_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_margin != 2'd3) && (df_margin != 2'd3));

   assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(acc_err) |-> $rose(cmd_done));

   assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(acc_err) |-> $past(err_clr));
endmodule

bind fmc_margin_unit fmc_margin_unit_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .launch_req (launch_req),
   .err_clr    (err_clr),
   .cmd_done   (cmd_done),
   .acc_err    (acc_err),
   .pf_margin  (pf_margin),
   .df_margin  (df_margin)
);

// File: tb/fmc_margin_unit_tb.sv
module fmc_margin_unit_tb;
   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        special_mode = 1'b1;
   logic        idx_we = 1'b0;
   logic [2:0]  idx_wdata = '0;
   logic        word_we = 1'b0;
   logic [15:0] word_wdata = '0;
   logic        launch_req = 1'b0;
   logic        err_clr = 1'b0;
   logic        cmd_done, acc_err, prot_viol;
   logic [1:0]  margin_stat, pf_margin, df_margin;

   int n_chk = 0;
   int n_fail = 0;
   logic [1:0] exp_pf = 2'd0;
   logic [1:0] exp_df = 2'd0;

   always #2 clk = ~clk;

   fmc_margin_unit #(.APPLY_LAT(LAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
      .idx_we(idx_we), .idx_wdata(idx_wdata),
      .word_we(word_we), .word_wdata(word_wdata),
      .launch_req(launch_req), .err_clr(err_clr),
      .cmd_done(cmd_done), .acc_err(acc_err), .prot_viol(prot_viol),
      .margin_stat(margin_stat), .pf_margin(pf_margin), .df_margin(df_margin)
   );

   task automatic check(input logic ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic expect_err(input logic mode, input logic [2:0] idx,
                                       input logic [7:0] code, input logic [7:0] addr,
                                       input logic [15:0] lvl);
      return !mode || idx != 3'd1 || code != 8'h0E ||
             (addr != 8'd3 && addr != 8'd0) || lvl > 16'd2;
   endfunction

   task automatic wr_idx(input logic [2:0] v);
      idx_we = 1'b1; idx_wdata = v;
      @(negedge clk); idx_we = 1'b0;
   endtask

   task automatic wr_word(input logic [15:0] v);
      word_we = 1'b1; word_wdata = v;
      @(negedge clk); word_we = 1'b0;
   endtask

   task automatic load(input logic [7:0] code, input logic [7:0] addr,
                       input logic [15:0] lvl, input logic [2:0] idx);
      wr_idx(3'd0); wr_word({code, addr});
      wr_idx(3'd1); wr_word(lvl);
      wr_idx(idx);
   endtask

   task automatic check_margins(input string req);
      check(pf_margin == exp_pf, req, pf_margin, exp_pf);
      check(df_margin == exp_df, req, df_margin, exp_df);
   endtask

   // launch and follow through to completion; clr_at_fail drives err_clr on the failure edge
   task automatic run(input logic mode, input logic [7:0] code, input logic [7:0] addr,
                      input logic [15:0] lvl, input logic [2:0] idx, input logic clr_at_fail);
      logic e;
      e = expect_err(mode, idx, code, addr, lvl);
      load(code, addr, lvl, idx);
      special_mode = mode;
      launch_req = 1'b1;
      @(negedge clk); launch_req = 1'b0;
      check(cmd_done == 1'b0, "R2", cmd_done, 0);
      if (e) begin
         err_clr = clr_at_fail;
         @(negedge clk); err_clr = 1'b0;
         check(cmd_done == 1'b1, "R10", cmd_done, 1);
         check(acc_err == 1'b1, clr_at_fail ? "R11" : "R5 R6 R7 R8 R9", acc_err, 1);
         check_margins("R10");
         @(negedge clk);
         check(acc_err == 1'b1, "R11", acc_err, 1);
         err_clr = 1'b1;
         @(negedge clk); err_clr = 1'b0;
         check(acc_err == 1'b0, "R11", acc_err, 0);
      end else begin
         for (int k = 1; k < LAT; k++) begin
            @(negedge clk);
            check(cmd_done == 1'b0, "R3", cmd_done, 0);
         end
         @(negedge clk);
         check(cmd_done == 1'b1, "R3", cmd_done, 1);
         if (addr == 8'd3) begin exp_pf = lvl[1:0]; exp_df = lvl[1:0]; end
         else exp_df = lvl[1:0];
         check_margins(addr == 8'd3 ? "R3" : "R4");
         check(acc_err == 1'b0, "R3", acc_err, 0);
      end
      check(prot_viol == 1'b0 && margin_stat == 2'b00, "R12", {prot_viol, margin_stat}, 0);
      special_mode = 1'b1;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      logic [7:0]  code, addr;
      logic [15:0] lvl;
      logic [2:0]  idx;
      logic        mode;
      void'($urandom(32'h5EED_0E0E));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(cmd_done == 1'b1, "R1", cmd_done, 1);
      check(acc_err == 1'b0, "R1", acc_err, 0);
      check_margins("R1");

      // directed: valid program-flash then data-flash targets
      run(1'b1, 8'h0E, 8'd3, 16'd1, 3'd1, 1'b0);   // R3
      run(1'b1, 8'h0E, 8'd0, 16'd2, 3'd1, 1'b0);   // R4
      run(1'b1, 8'h0E, 8'd0, 16'd0, 3'd1, 1'b0);   // R4 back to normal
      // directed failures
      run(1'b0, 8'h0E, 8'd3, 16'd2, 3'd1, 1'b0);   // R5
      run(1'b1, 8'h0E, 8'd3, 16'd2, 3'd0, 1'b0);   // R6
      run(1'b1, 8'h0E, 8'd3, 16'd2, 3'd2, 1'b0);   // R6
      run(1'b1, 8'h0E, 8'd1, 16'd2, 3'd1, 1'b0);   // R7
      run(1'b1, 8'h0E, 8'd3, 16'd3, 3'd1, 1'b0);   // R8
      run(1'b1, 8'h0E, 8'd3, 16'h0100, 3'd1, 1'b0); // R8 high bits
      run(1'b1, 8'h0F, 8'd3, 16'd1, 3'd1, 1'b0);   // R9
      // R11: clear and set land on the same edge
      run(1'b1, 8'h0E, 8'd2, 16'd1, 3'd1, 1'b1);

      // R13 / R2: writes and a second launch while busy are ignored
      load(8'h0E, 8'd3, 16'd2, 3'd1);
      launch_req = 1'b1;
      @(negedge clk);
      idx_we = 1'b1; idx_wdata = 3'd0;
      @(negedge clk); idx_we = 1'b0;
      word_we = 1'b1; word_wdata = 16'd3;
      @(negedge clk); word_we = 1'b0; launch_req = 1'b0;
      @(negedge clk);
      exp_pf = 2'd2; exp_df = 2'd2;
      check(cmd_done == 1'b1, "R2", cmd_done, 1);
      check_margins("R13");
      @(negedge clk);
      check(cmd_done == 1'b1, "R2", cmd_done, 1);
      // relaunch without reload: index and words must be as loaded
      launch_req = 1'b1;
      @(negedge clk); launch_req = 1'b0;
      repeat (LAT) @(negedge clk);
      check(cmd_done == 1'b1 && acc_err == 1'b0, "R13", {cmd_done, acc_err}, 2);
      check_margins("R13");

      // constrained random
      for (int i = 0; i < 300; i++) begin
         mode = ($urandom_range(9) != 0);
         code = ($urandom_range(9) != 0) ? 8'h0E : 8'($urandom_range(255));
         case ($urandom_range(3))
            0, 1: addr = 8'd3;
            2:    addr = 8'd0;
            default: addr = 8'($urandom_range(7));
         endcase
         lvl = ($urandom_range(7) != 0) ? 16'($urandom_range(4)) : 16'($urandom);
         idx = ($urandom_range(7) != 0) ? 3'd1 : 3'($urandom_range(7));
         run(mode, code, addr, lvl, idx, 1'($urandom_range(1)));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule